// File: doc/BRIEF.md
# Ternary Prefix Match Array with Segmented Search Lines

This block is a synthesizable ternary match array for IPv4 longest-prefix lookup. Each entry holds a valid flag, a 32-bit value and a 32-bit mask. A mask bit of 1 makes that bit position a don't-care. Software keeps the entries sorted with the longest prefixes at the lowest indices, so the first entry that hits is the longest prefix match. A search has two phases, chosen by the `phase` input. While `phase` is 0 (precharge) nothing is evaluated. While `phase` is 1 (evaluate) the key is compared against every entry at once. The hit flag and the index of the winning entry are registered at that edge.

The block also models the search-line network so that its switching can be measured. Each bit column of the key is carried down the array on a search line. That line is cut into segments of `SEG_G` rows, and the gating node of each segment sits at its first row. When the first row stores a don't-care in that column, the gating node stays closed and the whole segment keeps its previous search value. Search lines are never forced low during precharge, so a repeated key bit costs no transition. A counter adds one for every segment whose search value changes. A sticky error flag reports a closed gating node that hides a cared-for bit of a valid row, because such a row would be compared against a stale value.

Top module: `tcam_lpm`

## Requirements
- R1: During evaluation, a bit position whose stored mask bit is 1 never causes a mismatch, whatever the key bit is.
- R2: An entry hits only if its valid flag is 1 and every bit position with mask 0 equals the search value its segment applies. An entry that is not valid never hits.
- R3: At an evaluate edge, `hit` takes the OR of all entry hits and `hit_idx` takes the lowest hitting index. On a miss, `hit_idx` is 0. Both are visible after that edge.
- R4: While `phase` is 0, `hit`, `hit_idx`, `toggle_count`, `gate_err` and the search-line state all keep their values.
- R5: Search lines change only at evaluate edges and are never returned to 0 in between. Evaluating the same key twice in a row adds 0 to `toggle_count` on the second search.
- R6: At each evaluate edge, `toggle_count` increases by the number of (segment, column) search values that change. Segment s covers rows s*SEG_G to s*SEG_G+SEG_G-1.
- R7: If row s*SEG_G has mask bit 1 in column c, segment s keeps its previous value in column c. That segment then adds no toggle in that column, and its rows are compared against the held value.
- R8: `gate_err` is set at an evaluate edge if some valid row inside a segment has mask 0 in a column that the segment's gating row masks. Once set, it stays set until reset.
- R9: A write of valid, value and mask to entry `wr_addr` takes effect when `wr_en` is 1 and `phase` is 0. A write presented while `phase` is 1 is ignored.
- R10: After reset, no entry is valid, all search lines are 0, and `hit`, `hit_idx`, `toggle_count` and `gate_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | IDX_W (7) | Entry to write |
| wr_value | input | KEY_W (32) | Stored value bits |
| wr_mask | input | KEY_W (32) | Mask bits, 1 = don't care |
| wr_valid | input | 1 | Valid flag written with the entry |
| phase | input | 1 | 0 = precharge, 1 = evaluate |
| search_key | input | KEY_W (32) | Lookup key |
| hit | output | 1 | Registered hit flag |
| hit_idx | output | IDX_W (7) | Registered index of the lowest hitting entry |
| toggle_count | output | CNT_W (32) | Running count of search-line segment transitions |
| gate_err | output | 1 | Sticky flag for a cared-for bit hidden behind a closed gating node |

## Verification
The bench places an invalid /24 entry above a valid /16 entry. A design that ignored the valid flag would return the wrong index for a key inside the /24. It repeats a key and toggles the key during precharge: a design that cleared the search lines each cycle, or counted outside evaluation, would move the toggle counter. A row whose mask is all don't-cares is placed at a gating row. The bench then checks both that its segment adds no toggles and that the row still hits through the held search values. A later row in that segment with cared-for bits must set the error flag and keep it set. A write presented during evaluation must leave no trace in later searches.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    typedef enum logic {
        PH_PRECHARGE = 1'b0,
        PH_EVALUATE  = 1'b1
    } phase_e;

    // Segment that a row belongs to
    function automatic int unsigned seg_of(input int unsigned row, input int unsigned g);
        return row / g;
    endfunction

    // First row of a segment, where its gating node sits
    function automatic int unsigned gate_row(input int unsigned seg, input int unsigned g);
        return seg * g;
    endfunction

endpackage

// File: rtl/tcam_entry_store.sv
module tcam_entry_store #(
    parameter int ENTRIES = 128,
    parameter int KEY_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_addr,
    input  logic [KEY_W-1:0]                 wr_value,
    input  logic [KEY_W-1:0]                 wr_mask,
    input  logic                             wr_valid,
    input  logic                             eval_now,
    output logic [ENTRIES-1:0]               valid_vec,
    output logic [ENTRIES-1:0][KEY_W-1:0]    value_arr,
    output logic [ENTRIES-1:0][KEY_W-1:0]    mask_arr
);

    logic wr_take;
    assign wr_take = wr_en && !eval_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_vec <= '0;
            value_arr <= '0;
            mask_arr  <= '0;
        end else if (wr_take) begin
            valid_vec[wr_addr] <= wr_valid;
            value_arr[wr_addr] <= wr_value;
            mask_arr[wr_addr]  <= wr_mask;
        end
    end

endmodule

// File: rtl/tcam_search_lines.sv
module tcam_search_lines
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int KEY_W   = 32,
    parameter int SEG_G   = 8,
    parameter int CNT_W   = 32,
    localparam int NSEG   = ENTRIES / SEG_G,
    localparam int TW     = $clog2(KEY_W * NSEG + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             eval_now,
    input  logic [KEY_W-1:0]                 key,
    input  logic [ENTRIES-1:0]               valid_vec,
    input  logic [ENTRIES-1:0][KEY_W-1:0]    mask_arr,
    output logic [NSEG-1:0][KEY_W-1:0]       seg_key,
    output logic [CNT_W-1:0]                 toggle_count,
    output logic                             gate_err
);

    logic [NSEG-1:0][KEY_W-1:0] sl_q;
    logic [NSEG-1:0][KEY_W-1:0] sl_d;
    logic [NSEG-1:0][KEY_W-1:0] gate_open;
    logic [TW-1:0]              tog_now;
    logic                       err_now;

    // Gating node per segment and column: open unless the first row is X
    generate
        for (genvar s = 0; s < NSEG; s++) begin : g_seg
            localparam int GR = gate_row(s, SEG_G);
            for (genvar c = 0; c < KEY_W; c++) begin : g_col
                assign gate_open[s][c] = ~mask_arr[GR][c];
                assign sl_d[s][c]      = gate_open[s][c] ? key[c] : sl_q[s][c];
            end
        end
    endgenerate

    assign seg_key = sl_d;

    always_comb begin
        tog_now = '0;
        for (int s = 0; s < NSEG; s++) begin
            for (int c = 0; c < KEY_W; c++) begin
                tog_now = tog_now + TW'(sl_d[s][c] ^ sl_q[s][c]);
            end
        end
    end

    // A valid row that cares about a column hidden by a closed gate
    always_comb begin
        err_now = 1'b0;
        for (int s = 0; s < NSEG; s++) begin
            for (int c = 0; c < KEY_W; c++) begin
                for (int r = 1; r < SEG_G; r++) begin
                    if (!gate_open[s][c] && valid_vec[s*SEG_G + r]
                        && !mask_arr[s*SEG_G + r][c]) begin
                        err_now = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sl_q         <= '0;
            toggle_count <= '0;
            gate_err     <= 1'b0;
        end else if (eval_now) begin
            sl_q         <= sl_d;
            toggle_count <= toggle_count + CNT_W'(tog_now);
            gate_err     <= gate_err | err_now;
        end
    end

endmodule

// File: rtl/tcam_match_array.sv
module tcam_match_array
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int KEY_W   = 32,
    parameter int SEG_G   = 8,
    localparam int NSEG   = ENTRIES / SEG_G
) (
    input  logic [ENTRIES-1:0]               valid_vec,
    input  logic [ENTRIES-1:0][KEY_W-1:0]    value_arr,
    input  logic [ENTRIES-1:0][KEY_W-1:0]    mask_arr,
    input  logic [NSEG-1:0][KEY_W-1:0]       seg_key,
    output logic [ENTRIES-1:0]               match_vec
);

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_row
            localparam int S = seg_of(e, SEG_G);
            logic [KEY_W-1:0] pull_down;
            // A cell discharges its line only when it cares and differs
            assign pull_down    = ~mask_arr[e] & (value_arr[e] ^ seg_key[S]);
            assign match_vec[e] = valid_vec[e] & ~(|pull_down);
        end
    endgenerate

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tcam_lpm.sv
module tcam_lpm
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int KEY_W   = 32,
    parameter int SEG_G   = 8,
    parameter int CNT_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int NSEG   = ENTRIES / SEG_G
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic             wr_valid,
    input  logic             phase,
    input  logic [KEY_W-1:0] search_key,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [CNT_W-1:0] toggle_count,
    output logic             gate_err
);

    logic                          eval_now;
    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0][KEY_W-1:0] value_arr;
    logic [ENTRIES-1:0][KEY_W-1:0] mask_arr;
    logic [NSEG-1:0][KEY_W-1:0]    seg_key;
    logic [ENTRIES-1:0]            match_vec;
    logic                          any_d;
    logic [IDX_W-1:0]              idx_d;

    assign eval_now = (phase_e'(phase) == PH_EVALUATE);

    tcam_entry_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_valid(wr_valid),
        .eval_now(eval_now), .valid_vec(valid_vec),
        .value_arr(value_arr), .mask_arr(mask_arr)
    );

    tcam_search_lines #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .SEG_G(SEG_G), .CNT_W(CNT_W)) u_sl (
        .clk(clk), .rst(rst), .eval_now(eval_now), .key(search_key),
        .valid_vec(valid_vec), .mask_arr(mask_arr), .seg_key(seg_key),
        .toggle_count(toggle_count), .gate_err(gate_err)
    );

    tcam_match_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .SEG_G(SEG_G)) u_match (
        .valid_vec(valid_vec), .value_arr(value_arr), .mask_arr(mask_arr),
        .seg_key(seg_key), .match_vec(match_vec)
    );

    tcam_prio_enc #(.ENTRIES(ENTRIES)) u_prio (
        .req(match_vec), .any(any_d), .idx(idx_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit     <= 1'b0;
            hit_idx <= '0;
        end else if (eval_now) begin
            hit     <= any_d;
            hit_idx <= idx_d;
        end
    end

endmodule

// File: rtl/tcam_lpm_chk.sv
module tcam_lpm_chk #(
    parameter int ENTRIES = 128,
    parameter int CNT_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst,
    input logic               phase,
    input logic               wr_en,
    input logic               hit,
    input logic [IDX_W-1:0]   hit_idx,
    input logic [CNT_W-1:0]   toggle_count,
    input logic               gate_err,
    input logic [ENTRIES-1:0] valid_vec
);

    logic [ENTRIES-1:0] valid_prev;
    always_ff @(posedge clk) valid_prev <= valid_vec;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        gate_err |=> gate_err); // R8

    AST_PRECHARGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !phase |=> ($stable(hit) && $stable(hit_idx) && $stable(toggle_count) && $stable(gate_err))); // R4

    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_idx == '0)); // R3

    AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        phase |=> (!hit || valid_prev[hit_idx])); // R2

    AST_EVAL_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (phase && wr_en) |=> $stable(valid_vec)); // R9

endmodule

bind tcam_lpm tcam_lpm_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .phase(phase), .wr_en(wr_en), .hit(hit),
    .hit_idx(hit_idx), .toggle_count(toggle_count), .gate_err(gate_err),
    .valid_vec(valid_vec)
);

// File: tb/tcam_lpm_bench.sv
module tcam_lpm_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 128;
    localparam int KEY_W      = 32;
    localparam int SEG_G      = 8;
    localparam int CNT_W      = 32;
    localparam int NSEG       = ENTRIES / SEG_G;
    localparam int IDX_W      = $clog2(ENTRIES);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_addr = '0;
    logic [KEY_W-1:0] wr_value = '0;
    logic [KEY_W-1:0] wr_mask = '0;
    logic             wr_valid = 1'b0;
    logic             phase = 1'b0;
    logic [KEY_W-1:0] search_key = '0;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [CNT_W-1:0] toggle_count;
    logic             gate_err;

    tcam_lpm #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .SEG_G(SEG_G), .CNT_W(CNT_W)) u_tcam_lpm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_valid(wr_valid),
        .phase(phase), .search_key(search_key), .hit(hit), .hit_idx(hit_idx),
        .toggle_count(toggle_count), .gate_err(gate_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  done   = 0;

    // Behavioural reference state
    bit              m_valid [ENTRIES];
    bit [KEY_W-1:0]  m_val   [ENTRIES];
    bit [KEY_W-1:0]  m_msk   [ENTRIES];
    bit [KEY_W-1:0]  m_line  [NSEG];
    longint          m_cnt;
    bit              m_hit;
    int              m_idx;
    bit              m_err;

    function automatic bit [31:0] ip(input int a, input int b, input int c, input int d);
        return {a[7:0], b[7:0], c[7:0], d[7:0]};
    endfunction

    function automatic bit [31:0] pfx_mask(input int len);
        if (len >= 32) return 32'h0;
        return 32'hFFFF_FFFF >> len;
    endfunction

    task automatic model_reset();
        for (int e = 0; e < ENTRIES; e++) begin
            m_valid[e] = 0; m_val[e] = '0; m_msk[e] = '0;
        end
        for (int s = 0; s < NSEG; s++) m_line[s] = '0;
        m_cnt = 0; m_hit = 0; m_idx = 0; m_err = 0;
    endtask

    task automatic model_edge(input bit we, input int addr, input bit [31:0] val,
                              input bit [31:0] msk, input bit vld, input bit ph,
                              input bit [31:0] key);
        bit [KEY_W-1:0] nline [NSEG];
        if (ph) begin
            for (int s = 0; s < NSEG; s++) begin
                for (int c = 0; c < KEY_W; c++) begin
                    bit closed;
                    closed = m_msk[s*SEG_G][c];
                    nline[s][c] = closed ? m_line[s][c] : key[c];
                    if (nline[s][c] != m_line[s][c]) m_cnt++;
                    if (closed) begin
                        for (int r = s*SEG_G + 1; r < (s+1)*SEG_G; r++)
                            if (m_valid[r] && !m_msk[r][c]) m_err = 1;
                    end
                end
            end
            m_hit = 0; m_idx = 0;
            for (int e = 0; e < ENTRIES && !m_hit; e++) begin
                bit ok;
                ok = m_valid[e];
                for (int c = 0; c < KEY_W; c++)
                    if (!m_msk[e][c] && m_val[e][c] != nline[e / SEG_G][c]) ok = 0;
                if (ok) begin m_hit = 1; m_idx = e; end
            end
            for (int s = 0; s < NSEG; s++) m_line[s] = nline[s];
        end else if (we) begin
            m_valid[addr] = vld; m_val[addr] = val; m_msk[addr] = msk;
        end
    endtask

    // One clock: drive at the falling edge, update the model, compare at the next falling edge
    task automatic step(input bit we, input int addr, input bit [31:0] val,
                        input bit [31:0] msk, input bit vld, input bit ph,
                        input bit [31:0] key, input string tag);
        wr_en = we; wr_addr = IDX_W'(addr); wr_value = val; wr_mask = msk;
        wr_valid = vld; phase = ph; search_key = key;
        model_edge(we, addr, val, msk, vld, ph, key);
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (hit !== m_hit || int'(hit_idx) != m_idx || longint'(toggle_count) != m_cnt
            || gate_err !== m_err) begin
            n_bad++;
            $display("FAIL %s: hit=%0d idx=%0d cnt=%0d err=%0d expected hit=%0d idx=%0d cnt=%0d err=%0d",
                     tag, hit, hit_idx, toggle_count, gate_err, m_hit, m_idx, m_cnt, m_err);
        end
    endtask

    task automatic wr(input int addr, input bit [31:0] val, input int len, input bit vld,
                      input string tag);
        step(1, addr, val, pfx_mask(len), vld, 0, search_key, tag);
    endtask

    task automatic look(input bit [31:0] key, input string tag);
        step(0, 0, 0, 0, 0, 1, key, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        step(0, 0, 0, 0, 0, 0, 0, "R10");

        // R9: table loaded in precharge; /32, invalid /24, /16, /8
        wr(0, ip(10,1,2,3), 32, 1, "R9");
        wr(1, ip(10,1,2,0), 24, 0, "R9");
        wr(2, ip(10,1,0,0), 16, 1, "R9");
        wr(3, ip(10,0,0,0),  8, 1, "R9");

        look(ip(10,1,2,3), "R3");     // longest prefix wins, idx 0
        look(ip(10,1,2,5), "R2");     // invalid /24 skipped, idx 2
        look(ip(10,1,9,9), "R1");     // masked low half ignored
        look(ip(10,7,7,7), "R1");     // /8 only
        look(ip(11,0,0,0), "R3");     // miss, idx 0
        look(ip(11,0,0,0), "R5");     // same key, no toggles

        // R4: precharge with a changing key holds everything
        step(0, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, "R4");
        step(0, 0, 0, 0, 0, 0, 32'h1234_5678, "R4");

        // R6: full inversions of the key
        look(32'h0000_0000, "R6");
        look(32'hFFFF_FFFF, "R6");
        look(32'h0F0F_0F0F, "R6");

        // R9: a write during evaluation is ignored
        step(1, 5, ip(192,168,0,0), pfx_mask(16), 1, 1, ip(1,2,3,4), "R9");
        look(ip(192,168,1,1), "R9");

        // R7: all-X row at gating row 16 closes segment 2 in every column
        wr(16, 32'h0, 0, 1, "R7");
        look(ip(11,0,0,0), "R7");
        look(ip(200,9,8,7), "R7");
        look(32'h5555_AAAA, "R7");

        // R8: a cared-for valid row hidden behind the closed gate
        wr(17, ip(44,0,0,0), 8, 1, "R8");
        look(ip(44,0,0,0), "R8");
        step(0, 0, 0, 0, 0, 0, 0, "R8");
        look(ip(10,1,2,3), "R8");
        wr(17, 32'h0, 0, 0, "R8");
        look(ip(44,1,1,1), "R8");

        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule